// File: doc/BRIEF.md
# Free-running tick counter with consistent snapshot read

The block keeps a free-running up-counter, 64 bits wide by default, that advances by one on every clock in which `tick_en` is high. Software reads it over a 32-bit register port. A direct read of a counter this wide over a 32-bit port can tear when the low half carries into the high half between the two reads. The block avoids this with a snapshot handshake. Software writes a request bit in the control word. The hardware copies the live count into a pair of holding words and then drops the request bit. Software polls the bit until it reads 0, then reads the two holding words in either order.

The counter and the register port share one clock. The slow time base enters as a one-cycle tick enable, so the block has no clock-domain crossing. Register reads are combinational from `bus_addr` and have no side effects. A write takes effect at the clock edge where `bus_we` is high. The block has no data stream, so the port has no valid/ready handshake.

Top module: `snapctr_top`

## Requirements
- R1: After reset the live counter and both holding words are zero, and the request bit (bit 1 of the control word at offset 0xA0) reads 0.
- R2: The live counter increases by exactly one at each clock edge where `tick_en` is 1. It holds its value at each edge where `tick_en` is 0.
- R3: A write to offset 0xA0 with bit 1 of `bus_wdata` set starts a snapshot when none is pending. From the next cycle on, bit 1 of the control word reads 1.
- R4: With the default delay of 2, the holding words load at the second clock edge after the request write. They load the live count held in the cycle just before that edge, and the request bit reads 0 from that same edge on.
- R5: Offset 0xA4 returns holding bits 31:0 and offset 0xA8 returns holding bits 63:32. The two reads can come in any order and any number of times, and they always yield the same 64-bit value.
- R6: The holding words keep their value until the next snapshot completes, while the live counter keeps running.
- R7: While a snapshot is pending, a control write with bit 1 clear does not cancel it. A control write with bit 1 set does not restart its timing. This includes a write in the cycle where the snapshot completes.
- R8: The counter wraps from all ones to zero. When the counter is narrower than 64 bits (parameter `CNT_W`), the holding words are zero-extended.
- R9: Reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by the counter and the register port |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable, one pulse per time-base tick |
| bus_we | input | 1 | Register write strobe, taken at the clock edge |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational register read data |

## Verification
The assertions assume that `tick_en`, `bus_we`, `bus_addr` and `bus_wdata` are known values at every clock edge after reset. They also assume that the snapshot delay parameter is at least 1, so a capture always comes after its request. The stimulus drives every input on the falling edge, holds it through the next rising edge, and keeps `bus_we` low except on control writes. Reads only change `bus_addr`, so a read cannot disturb the state it observes.

// File: rtl/snapctr_pkg.sv
package snapctr_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;
  // Offsets software relies on for the handshake and the two words
  localparam logic [ADDR_W-1:0] OFS_CTL = 8'hA0;
  localparam logic [ADDR_W-1:0] OFS_LO  = 8'hA4;
  localparam logic [ADDR_W-1:0] OFS_HI  = 8'hA8;
  localparam int REQ_BIT = 1;
  localparam int WIDE_W  = 2 * BUS_W;
endpackage

// File: rtl/snapctr_count.sv
module snapctr_count #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (tick_en) count <= count + 1'b1;
  end
endmodule

// File: rtl/snapctr_latch.sv
module snapctr_latch #(
  parameter int LATCH_DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic pend,
  output logic capture
);
  localparam int DW = (LATCH_DLY > 1) ? $clog2(LATCH_DLY) : 1;
  localparam logic [DW-1:0] DLY_LOAD = DW'(LATCH_DLY - 1);

  logic [DW-1:0] dly;

  assign capture = pend && (dly == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      dly  <= '0;
    end else if (pend) begin
      if (dly == '0) pend <= 1'b0;
      else           dly  <= dly - 1'b1;
    end else if (req) begin
      pend <= 1'b1;
      dly  <= DLY_LOAD;
    end
  end
endmodule

// File: rtl/snapctr_regs.sv
module snapctr_regs
  import snapctr_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              pend,
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] addr,
  output logic [BUS_W-1:0]  rdata,
  output logic [CNT_W-1:0]  hold
);
  logic [WIDE_W-1:0] wide;

  always_ff @(posedge clk) begin
    if (!rst_n)       hold <= '0;
    else if (capture) hold <= count;
  end

  always_comb begin
    wide = '0;
    wide[CNT_W-1:0] = hold;
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      OFS_CTL: rdata[REQ_BIT] = pend;
      OFS_LO:  rdata = wide[BUS_W-1:0];
      OFS_HI:  rdata = wide[WIDE_W-1:BUS_W];
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/snapctr_top.sv
module snapctr_top
  import snapctr_pkg::*;
#(
  parameter int CNT_W     = 64,
  parameter int LATCH_DLY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata
);
  logic [CNT_W-1:0] count_w;
  logic [CNT_W-1:0] hold_w;
  logic             pend_w;
  logic             cap_w;
  logic             req_w;

  assign req_w = bus_we && (bus_addr == OFS_CTL) && bus_wdata[REQ_BIT];

  snapctr_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .count(count_w)
  );

  snapctr_latch #(.LATCH_DLY(LATCH_DLY)) u_latch (
    .clk(clk), .rst_n(rst_n), .req(req_w), .pend(pend_w), .capture(cap_w)
  );

  snapctr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .capture(cap_w), .pend(pend_w),
    .count(count_w), .addr(bus_addr), .rdata(bus_rdata), .hold(hold_w)
  );
endmodule

// File: rtl/snapctr_chk.sv
module snapctr_chk #(
  parameter int CNT_W     = 64,
  parameter int LATCH_DLY = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             pend,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] hold
);
  localparam int AW = $clog2(LATCH_DLY + 2) + 1;
  localparam logic [AW-1:0] LAST_AGE = AW'(LATCH_DLY - 1);

  logic [AW-1:0] age;

  always_ff @(posedge clk) begin
    if (!rst_n || !pend) age <= '0;
    else                 age <= age + 1'b1;
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> count == $past(count) + 1'b1);

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(count));

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> $stable(hold));

  assert_capture_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && age == LAST_AGE) |=> (hold == $past(count)) && !pend);

  assert_no_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && age < LAST_AGE) |=> pend);
endmodule

bind snapctr_top snapctr_chk #(.CNT_W(CNT_W), .LATCH_DLY(LATCH_DLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
  .pend(pend_w), .count(count_w), .hold(hold_w)
);

// File: tb/tb_snapctr_top.sv
module tb_snapctr_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] s_rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [63:0] exp_cnt = '0;
  logic [63:0] last_snap = '0;

  always #10 clk = ~clk;

  snapctr_top dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  snapctr_top #(.CNT_W(6)) dut_small (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(s_rdata)
  );

  // Reference count from R1/R2
  always @(posedge clk) begin
    if (!rst_n)       exp_cnt <= '0;
    else if (tick_en) exp_cnt <= exp_cnt + 1;
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] ds);
    bus_addr = a;
    #1;
    d  = bus_rdata;
    ds = s_rdata;
  endtask

  task automatic read64(output logic [63:0] v, output logic [31:0] small_lo);
    logic [31:0] lo, hi, ds, dsh;
    rd(8'hA8, hi, dsh);
    rd(8'hA4, lo, ds);
    v = {hi, lo};
    small_lo = ds;
    chk("R8 small high word zero", {32'h0, dsh}, 64'h0);
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Request, poll, and check; called just after a falling edge
  task automatic do_latch(string tag, bit meddle);
    logic [31:0] d, ds, slo;
    logic [63:0] snap, got;
    bus_we = 1'b1; bus_addr = 8'hA0; bus_wdata = 32'h2;
    @(posedge clk); @(negedge clk);
    if (meddle) bus_wdata = 32'h0; else bus_we = 1'b0;
    #1;
    bus_we = meddle;
    rd(8'hA0, d, ds);
    chk({tag, " R3 request pending"}, {63'h0, d[1]}, 64'h1);
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
    rd(8'hA0, d, ds);
    chk({tag, " R3/R7 still pending before capture"}, {63'h0, d[1]}, 64'h1);
    snap = exp_cnt;
    if (meddle) begin
      bus_we = 1'b1; bus_addr = 8'hA0; bus_wdata = 32'h2;
    end
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
    rd(8'hA0, d, ds);
    chk({tag, " R4 request cleared"}, {63'h0, d[1]}, 64'h0);
    read64(got, slo);
    chk({tag, " R4/R5 snapshot value"}, got, snap);
    chk({tag, " R8 narrow wrapped snapshot"}, {32'h0, slo}, {58'h0, snap[5:0]});
    last_snap = snap;
    if (meddle) begin
      wait_cyc(2);
      rd(8'hA0, d, ds);
      chk({tag, " R7 late request not restarted"}, {63'h0, d[1]}, 64'h0);
    end
  endtask

  task automatic t_reset;
    logic [31:0] d, ds;
    rd(8'hA0, d, ds); chk("R1 request bit after reset", {32'h0, d}, 64'h0);
    rd(8'hA4, d, ds); chk("R1 low word after reset", {32'h0, d}, 64'h0);
    rd(8'hA8, d, ds); chk("R1 high word after reset", {32'h0, d}, 64'h0);
  endtask

  task automatic t_basic;
    tick_en = 1'b1;
    wait_cyc(5);
    do_latch("basic", 1'b0);
  endtask

  task automatic t_order;
    logic [63:0] a, b;
    logic [31:0] lo, hi, ds;
    logic [63:0] first;
    first = last_snap;
    rd(8'hA4, lo, ds); rd(8'hA8, hi, ds);
    chk("R5 low-then-high order", {hi, lo}, first);
    read64(a, ds);
    read64(b, ds);
    chk("R5 repeated read unchanged", b, a);
    wait_cyc(20);
    read64(a, ds);
    chk("R6 holding kept while counting", a, first);
    do_latch("second", 1'b0);
    chk("R2 counter advanced by ticks", {63'h0, (last_snap - first) >= 64'd20}, 64'h1);
  endtask

  task automatic t_freeze;
    logic [63:0] a;
    tick_en = 1'b0;
    wait_cyc(2);
    do_latch("frozen1", 1'b0);
    a = last_snap;
    wait_cyc(7);
    do_latch("frozen2", 1'b0);
    chk("R2 no advance without tick", last_snap, a);
    tick_en = 1'b1;
  endtask

  task automatic t_nocancel;
    wait_cyc(3);
    do_latch("meddle", 1'b1);
  endtask

  task automatic t_wrap;
    wait_cyc(90);
    do_latch("wrap", 1'b0);
    chk("R8 narrow counter passed its range", {63'h0, exp_cnt > 64'd64}, 64'h1);
  endtask

  task automatic t_other;
    logic [31:0] d, ds;
    rd(8'h00, d, ds); chk("R9 unmapped 0x00", {32'h0, d}, 64'h0);
    rd(8'hAC, d, ds); chk("R9 unmapped 0xAC", {32'h0, d}, 64'h0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_order();
    t_freeze();
    t_nocancel();
    t_wrap();
    t_other();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule